// File: doc/BRIEF.md
# Connection Memory Block-Fill Engine

This block loads one programmed pattern into every word of a switching connection memory. It sits between a mode register write port and the connection memory write port. Software writes a 5-bit pattern and sets a start bit in the same register write. The block then sweeps the memory address space. It writes the pattern into the top five bits of each word and zeros into the remaining bits.

The operation is paced by a one-clock frame-start pulse. It finishes on the second frame pulse after it is armed, and the partial frame that is in progress at arming counts as the first frame. On completion the start bit clears itself, so software can poll it. Software can abort a fill at any time in two ways: by writing the start bit to zero, or by dropping the block-programming master enable that comes from a separate control register. While a fill runs, ordinary host writes to the memory are held off and a busy output is raised. The block assumes that a frame lasts at least `DEPTH` clocks.

Top module: `cm_fill_engine`

## Requirements
- R1: The mode register resets to 0. A write stores bits 9..0 of the write data, and a read returns them with bits 15..10 forced to zero. The layout is: pattern in bits 9..5, start bit in bit 4, and general mode bits in bits 3..0.
- R2: A fill begins only when a register write changes the start bit from 0 to 1 while the master enable is 1. Any other write leaves the memory port untouched.
- R3: A fill writes every address from 0 to DEPTH-1 exactly once, in ascending order, one per clock. The first write is in the cycle after the starting write.
- R4: Each fill write carries the pattern in bits 15..11 and zero in bits 10..0.
- R5: The pattern is taken from the starting write. A write with the start bit set that arrives during a fill does not change the register or the fill data.
- R6: The fill ends on the second frame pulse after arming. A pulse in the same cycle as the starting write is not counted. At that clock edge the busy output and the start bit both fall.
- R7: Writing the start bit to 0 during a fill aborts it at that edge. No further sweep writes occur, and words already written keep their new value.
- R8: Dropping the master enable during a fill aborts it at that edge and also clears the start bit.
- R9: When idle, host writes pass to the memory port unchanged. While busy, host writes are dropped.
- R10: The busy output is high from the edge after the starting write until completion or abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_pulse | input | 1 | One-clock frame-start marker |
| bulk_master | input | 1 | Block-programming master enable from the control register |
| mode_wr_en | input | 1 | Mode register write strobe |
| mode_wr_data | input | 16 | Mode register write data |
| mode_rd_data | output | 16 | Mode register readback |
| host_cm_we | input | 1 | Host memory write strobe |
| host_cm_addr | input | ADDR_W | Host memory write address |
| host_cm_data | input | WORD_W | Host memory write data |
| cm_we | output | 1 | Connection memory write strobe |
| cm_addr | output | ADDR_W | Connection memory write address |
| cm_wdata | output | WORD_W | Connection memory write data |
| fill_busy | output | 1 | Fill in progress |

## Verification
The hardest situations to reach are the two abort paths in the middle of a sweep. The bench must show that no write slips out after the aborting edge, and that words on both sides of the stop point keep the right contents. To reach them, the stimulus lines each fill up a few clocks after a frame pulse. It then fires the abort a fixed number of clocks into the sweep, well before the next pulse could end the fill. Immediately after the aborting edge it empties the scoreboard, so any later write is reported as unexpected. A mid-fill rewrite with a different pattern, and a host write made after the sweep but before the second pulse, cover the hold-off cases.

// File: rtl/cmf_pkg.sv
// Shared field layout of the fill mode register.
// Assumes a 16-bit register with 10 stored bits.
package cmf_pkg;
    localparam int REG_W     = 16;
    localparam int STORED_W  = 10;
    localparam int PAT_W     = 5;
    localparam int BEGIN_BIT = 4;
    localparam int MISC_W    = 4;

    typedef struct packed {
        logic [PAT_W-1:0]  pattern;   // bits 9..5
        logic              begin_en;  // bit 4
        logic [MISC_W-1:0] misc;      // bits 3..0
    } mode_reg_t;
endpackage

// File: rtl/cmf_mode_ctl.sv
// Mode register plus fill control. It detects the rising start bit,
// raises the active state, and handles self-clear and both abort paths.
// Assumes that frame_done is only asserted while active.
module cmf_mode_ctl
    import cmf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [STORED_W-1:0] wr_data,
    input  logic                master,
    input  logic                frame_done,
    output mode_reg_t           reg_q,
    output logic                active,
    output logic                start
);
    logic wr_begin;
    logic abort_wr;
    logic abort_ms;

    // Decode the start edge and the two abort causes.
    always_comb begin
        wr_begin = wr_data[BEGIN_BIT];
        start    = wr_en && wr_begin && !reg_q.begin_en && master && !active;
        abort_wr = active && wr_en && !wr_begin;
        abort_ms = active && !master;
    end

    // Register storage. Rewrites are ignored while a fill holds the start bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            if (wr_en && !(active && wr_begin))
                reg_q <= mode_reg_t'(wr_data);
            if (frame_done || abort_ms)
                reg_q.begin_en <= 1'b0;
        end
    end

    // Active state: set on start, cleared on completion or abort.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= 1'b0;
        else if (start)
            active <= 1'b1;
        else if (abort_wr || abort_ms || frame_done)
            active <= 1'b0;
    end
endmodule

// File: rtl/cmf_frame_ctr.sv
// Counts frame pulses while a fill is active and flags the last one.
// Assumes start and active are never high together.
module cmf_frame_ctr #(
    parameter int FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic active,
    input  logic frame_pulse,
    output logic frame_done
);
    localparam int CNT_W = $clog2(FRAMES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAMES - 1);

    logic [CNT_W-1:0] cnt;

    // Flag the pulse that closes the final frame.
    always_comb frame_done = active && frame_pulse && (cnt == LAST);

    // Frame counter, restarted by each new fill.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= '0;
        else if (active && frame_pulse)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cmf_sweep.sv
// Address generator. It issues one write per clock from 0 to DEPTH-1.
// Assumes that a frame is at least DEPTH clocks long.
module cmf_sweep #(
    parameter int DEPTH = 512
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     active,
    output logic                     sweep_we,
    output logic [$clog2(DEPTH)-1:0] sweep_addr
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic sweeping;

    // A write is issued only while the fill is still active.
    always_comb sweep_we = sweeping && active;

    // Step the address and stop after the last word or on abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweeping   <= 1'b0;
            sweep_addr <= '0;
        end else if (start) begin
            sweeping   <= 1'b1;
            sweep_addr <= '0;
        end else if (!active) begin
            sweeping   <= 1'b0;
        end else if (sweeping) begin
            if (sweep_addr == LAST)
                sweeping <= 1'b0;
            else
                sweep_addr <= sweep_addr + 1'b1;
        end
    end
endmodule

// File: rtl/cmf_port_mux.sv
// Selects between the fill engine and the host for the memory port.
// While busy the host is dropped; the fill data is the pattern over zeros.
module cmf_port_mux #(
    parameter int ADDR_W = 9,
    parameter int WORD_W = 16,
    parameter int PAT_W  = 5
) (
    input  logic              busy,
    input  logic              sweep_we,
    input  logic [ADDR_W-1:0] sweep_addr,
    input  logic [PAT_W-1:0]  pattern,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_data,
    output logic              cm_we,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [WORD_W-1:0] cm_wdata
);
    // Port select: the fill owns the memory for the whole busy window.
    always_comb begin
        if (busy) begin
            cm_we    = sweep_we;
            cm_addr  = sweep_addr;
            cm_wdata = {pattern, {(WORD_W - PAT_W){1'b0}}};
        end else begin
            cm_we    = host_we;
            cm_addr  = host_addr;
            cm_wdata = host_data;
        end
    end
endmodule

// File: rtl/cm_fill_engine.sv
// Connection memory block-fill engine, top level.
// Assumes that a frame is at least DEPTH clocks long and frame_pulse is one clock wide.
module cm_fill_engine
    import cmf_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int WORD_W = 16,
    parameter int FRAMES = 2,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_pulse,
    input  logic              bulk_master,
    input  logic              mode_wr_en,
    input  logic [REG_W-1:0]  mode_wr_data,
    output logic [REG_W-1:0]  mode_rd_data,
    input  logic              host_cm_we,
    input  logic [ADDR_W-1:0] host_cm_addr,
    input  logic [WORD_W-1:0] host_cm_data,
    output logic              cm_we,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [WORD_W-1:0] cm_wdata,
    output logic              fill_busy
);
    mode_reg_t         reg_q;
    logic              active;
    logic              start;
    logic              frame_done;
    logic              sweep_we;
    logic [ADDR_W-1:0] sweep_addr;
    logic              unused_hi;

    // The upper write bits are reserved and dropped.
    assign unused_hi = ^mode_wr_data[REG_W-1:STORED_W];

    // Readback with the reserved bits forced to zero.
    always_comb begin
        mode_rd_data = {{(REG_W - STORED_W){1'b0}}, reg_q};
        fill_busy    = active;
    end

    cmf_mode_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (mode_wr_en),
        .wr_data    (mode_wr_data[STORED_W-1:0]),
        .master     (bulk_master),
        .frame_done (frame_done),
        .reg_q      (reg_q),
        .active     (active),
        .start      (start)
    );

    cmf_frame_ctr #(.FRAMES(FRAMES)) u_frm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .active      (active),
        .frame_pulse (frame_pulse),
        .frame_done  (frame_done)
    );

    cmf_sweep #(.DEPTH(DEPTH)) u_swp (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .active     (active),
        .sweep_we   (sweep_we),
        .sweep_addr (sweep_addr)
    );

    cmf_port_mux #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PAT_W(PAT_W)) u_mux (
        .busy       (active),
        .sweep_we   (sweep_we),
        .sweep_addr (sweep_addr),
        .pattern    (reg_q.pattern),
        .host_we    (host_cm_we),
        .host_addr  (host_cm_addr),
        .host_data  (host_cm_data),
        .cm_we      (cm_we),
        .cm_addr    (cm_addr),
        .cm_wdata   (cm_wdata)
    );
endmodule

// File: rtl/cmf_checker.sv
// Property checker for cm_fill_engine, attached through bind.
module cmf_checker #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bulk_master,
    input logic              mode_wr_en,
    input logic              wr_begin,
    input logic              rd_begin,
    input logic [4:0]        rd_pattern,
    input logic              host_cm_we,
    input logic              cm_we,
    input logic [ADDR_W-1:0] cm_addr,
    input logic [10:0]       cm_low,
    input logic              fill_busy
);
    AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_busy) |-> $past(mode_wr_en && wr_begin && bulk_master));  // R2

    AST_ADDR_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_busy && cm_we && $past(fill_busy && cm_we)) |-> (cm_addr == $past(cm_addr) + 1'b1));  // R3

    AST_LOW_FIELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_busy && cm_we) |-> (cm_low == '0));  // R4

    AST_PATTERN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_busy && $past(fill_busy)) |-> $stable(rd_pattern));  // R5

    AST_BEGIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fill_busy) |-> !rd_begin);  // R6

    AST_ABORT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_busy && mode_wr_en && !wr_begin) |=> !fill_busy);  // R7

    AST_ABORT_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        !bulk_master |=> (!fill_busy && !cm_we) || host_cm_we);  // R8

    AST_HOST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_busy |-> (cm_we == host_cm_we));  // R9
endmodule

bind cm_fill_engine cmf_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bulk_master (bulk_master),
    .mode_wr_en  (mode_wr_en),
    .wr_begin    (mode_wr_data[4]),
    .rd_begin    (mode_rd_data[4]),
    .rd_pattern  (mode_rd_data[9:5]),
    .host_cm_we  (host_cm_we),
    .cm_we       (cm_we),
    .cm_addr     (cm_addr),
    .cm_low      (cm_wdata[10:0]),
    .fill_busy   (fill_busy)
);

// File: tb/cm_fill_engine_tb_top.sv
`timescale 1ns/1ps
module cm_fill_engine_tb_top;
    localparam int DEPTH     = 512;
    localparam int ADDR_W    = $clog2(DEPTH);
    localparam int FRAME_LEN = 600;

    typedef struct packed {
        logic [ADDR_W-1:0] a;
        logic [15:0]       d;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_pulse = 1'b0;
    logic              bulk_master = 1'b0;
    logic              mode_wr_en = 1'b0;
    logic [15:0]       mode_wr_data = '0;
    logic [15:0]       mode_rd_data;
    logic              host_cm_we = 1'b0;
    logic [ADDR_W-1:0] host_cm_addr = '0;
    logic [15:0]       host_cm_data = '0;
    logic              cm_we;
    logic [ADDR_W-1:0] cm_addr;
    logic [15:0]       cm_wdata;
    logic              fill_busy;

    int    vectors = 0;
    int    fails = 0;
    item_t exp_q[$];
    logic [15:0] mem [DEPTH];
    int    frame_cnt = 0;

    always #2.5 clk = ~clk;

    cm_fill_engine dut_i (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .bulk_master(bulk_master),
        .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data), .mode_rd_data(mode_rd_data),
        .host_cm_we(host_cm_we), .host_cm_addr(host_cm_addr), .host_cm_data(host_cm_data),
        .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata), .fill_busy(fill_busy)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Frame pulse generator, one clock wide every FRAME_LEN clocks.
    always @(negedge clk) begin
        if (!rst_n) begin
            frame_cnt   <= 0;
            frame_pulse <= 1'b0;
        end else begin
            frame_cnt   <= (frame_cnt == FRAME_LEN - 1) ? 0 : frame_cnt + 1;
            frame_pulse <= (frame_cnt == FRAME_LEN - 1);
        end
    end

    // Monitor: each memory write is compared against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && cm_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7/R9 unexpected write", {cm_addr, cm_wdata}, 32'h0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(cm_addr == e.a && cm_wdata == e.d, "R3/R4 write item",
                      {cm_addr, cm_wdata}, {e.a, e.d});
            end
            mem[cm_addr] = cm_wdata;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [15:0] v);
        @(negedge clk);
        mode_wr_en   = 1'b1;
        mode_wr_data = v;
        @(negedge clk);
        mode_wr_en   = 1'b0;
    endtask

    task automatic host_write(input logic [ADDR_W-1:0] a, input logic [15:0] d, input bit expect_pass);
        @(negedge clk);
        if (expect_pass) exp_q.push_back('{a: a, d: d});
        host_cm_we = 1'b1; host_cm_addr = a; host_cm_data = d;
        @(negedge clk);
        host_cm_we = 1'b0;
    endtask

    task automatic push_fill(input logic [4:0] pat);
        for (int i = 0; i < DEPTH; i++)
            exp_q.push_back('{a: ADDR_W'(i), d: {pat, 11'b0}});
    endtask

    task automatic wait_pulse();
        @(posedge clk iff frame_pulse);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 16'hFFFF;
        cycles(5);
        rst_n = 1'b1;
        cycles(1);

        // R1 reset state
        check(mode_rd_data == 16'h0, "R1 reset readback", mode_rd_data, 16'h0);
        check(!fill_busy && !cm_we, "R10 idle after reset", {fill_busy, cm_we}, 0);

        // R1 reserved bits read zero
        reg_write(16'hFFEF);
        check(mode_rd_data == 16'h03EF, "R1 readback", mode_rd_data, 16'h03EF);
        reg_write(16'h0000);

        // R9 host write passes when idle
        host_write(7, 16'h1234, 1'b1);
        check(mem[7] == 16'h1234, "R9 host pass", mem[7], 16'h1234);

        // R2 no fill without master
        reg_write(16'h0010 | (16'h0C << 5));
        cycles(50);
        check(!fill_busy, "R2 no start without master", fill_busy, 0);
        reg_write(16'h0000);

        // Main fill with pattern 0x15
        bulk_master = 1'b1;
        wait_pulse();
        cycles(37);
        push_fill(5'h15);
        reg_write((16'h15 << 5) | 16'h0013);
        check(fill_busy, "R10 busy after start", fill_busy, 1);
        cycles(10);
        reg_write((16'h0A << 5) | 16'h0013);
        check(mode_rd_data == ((16'h15 << 5) | 16'h0013), "R5 pattern held",
              mode_rd_data, (16'h15 << 5) | 16'h0013);
        wait_pulse();
        @(negedge clk);
        check(fill_busy, "R6 busy after first pulse", fill_busy, 1);
        host_write(5, 16'hABCD, 1'b0);  // R9 dropped while busy
        wait_pulse();
        @(negedge clk);
        check(!fill_busy, "R6 done on second pulse", fill_busy, 0);
        check(mode_rd_data[4] == 1'b0, "R6 begin self-clear", mode_rd_data, 0);
        check(exp_q.size() == 0, "R3 all words written", exp_q.size(), 0);
        begin
            int bad = 0;
            for (int i = 0; i < DEPTH; i++) if (mem[i] !== 16'hA800) bad++;
            check(bad == 0, "R4 memory contents", bad, 0);
        end
        check(mem[5] == 16'hA800, "R9 host blocked", mem[5], 16'hA800);

        // R7 abort by writing the start bit low
        wait_pulse();
        cycles(5);
        push_fill(5'h03);
        reg_write((16'h03 << 5) | 16'h0010);
        cycles(100);
        @(negedge clk);
        mode_wr_en = 1'b1; mode_wr_data = 16'h0060;
        @(posedge clk);
        #1 exp_q.delete();
        @(negedge clk);
        mode_wr_en = 1'b0;
        check(!fill_busy, "R7 busy drops on abort", fill_busy, 0);
        cycles(200);
        check(mem[0] == 16'h1800, "R7 written word kept", mem[0], 16'h1800);
        check(mem[DEPTH-1] == 16'hA800, "R7 later words untouched", mem[DEPTH-1], 16'hA800);

        // R8 abort by dropping master
        wait_pulse();
        cycles(5);
        push_fill(5'h1F);
        reg_write((16'h1F << 5) | 16'h0010);
        cycles(50);
        @(negedge clk);
        bulk_master = 1'b0;
        @(posedge clk);
        #1 exp_q.delete();
        @(negedge clk);
        check(!fill_busy, "R8 busy drops", fill_busy, 0);
        check(mode_rd_data[4] == 1'b0, "R8 begin cleared", mode_rd_data, 0);
        cycles(100);
        check(mem[DEPTH-1] == 16'hA800, "R8 later words untouched", mem[DEPTH-1], 16'hA800);
        bulk_master = 1'b1;

        // R9 host path restored after abort
        host_write(9, 16'h5A5A, 1'b1);
        check(mem[9] == 16'h5A5A, "R9 host pass after abort", mem[9], 16'h5A5A);

        cycles(5);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule